// File: doc/BRIEF.md
# Root Error Collector

This block sits on the root-port side of error reporting. It accepts error messages, one per cycle. Each message carries a 2-bit severity and a 16-bit source ID that names the requester. The block keeps a root error status register. It records in a source register the source ID of the first correctable message and of the first uncorrectable message. When a message brings in a condition that software has enabled, it raises a one-cycle interrupt request.

Software sees three words through a simple register port, each read back combinationally from `reg_addr`:
- address 0 is the command (enable) register;
- address 1 is the status register, whose bits are cleared by writing 1;
- address 2 is the read-only source register.

Later messages of a class that has already been recorded leave the stored source ID alone and set a "multiple" flag. An interrupt is raised only when no enabled condition was already pending. Software therefore receives one notification per batch of errors, and can read back the first source that caused the batch.

Top module: `rterr_collector`

## Requirements
- R1: A correctable message (severity 0) that arrives while status bit 0 (correctable received) is clear loads its source ID into source register bits 15:0 and sets status bit 0.
- R2: A correctable message that arrives while status bit 0 is already set sets status bit 1 (multiple correctable) and leaves source bits 15:0 unchanged.
- R3: A non-fatal message (severity 1) sets status bit 5. A fatal message (severity 2) sets status bit 6.
- R4: A fatal message sets status bit 4 (first uncorrectable was fatal) only if status bit 2 was clear before it. Otherwise bit 4 keeps its value.
- R5: A non-fatal or fatal message that arrives while status bit 2 (uncorrectable received) is clear loads its source ID into source bits 31:16. If bit 2 is already set, the message sets status bit 3 (multiple uncorrectable) and leaves source bits 31:16 unchanged. In both cases it sets bit 2.
- R6: `irq_o` is high for exactly the one cycle after the clock edge that accepts a message. This happens when the message's severity is enabled in the command register, where bit 0 enables correctable, bit 1 non-fatal and bit 2 fatal.
- R7: No interrupt is raised for a message whose severity is not enabled in the command register.
- R8: No interrupt is raised when, before the message, an enabled condition was already pending. Status bit 0 maps to command bit 0, status bit 5 to command bit 1, and status bit 6 to command bit 2.
- R9: A message with severity 3 is illegal. It changes no status bit and no source field, and raises no interrupt.
- R10: Writing to address 1 clears each status bit whose write-data bit is 1, and leaves the other bits alone. When a clear and a message fall in the same cycle, the bits that the message sets end up set. All decisions about "already set" use the status held before that cycle.
- R11: After reset the command, status and source registers read 0 and `irq_o` is low.
- R12: Writing to address 0 stores write-data bits 2:0 as the command register, which reads back zero-extended. Writes to address 2 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_valid | input | 1 | An error message is present this cycle |
| msg_sev | input | 2 | Severity: 0 correctable, 1 non-fatal, 2 fatal, 3 illegal |
| msg_src | input | 16 | Source ID of the requester |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 command, 1 status, 2 source |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_o | output | 1 | One-cycle interrupt request |

## Verification
A message that is present at a rising edge takes effect at that same edge, in the status and source registers and in `irq_o`. Its results are therefore due one edge after the message is applied. The bench drives inputs on the falling edge and samples `irq_o` on the next falling edge. It then steps `reg_addr` to read status and source before the following rising edge. Exactly one edge later the bench checks that `irq_o` has dropped again. A sweep covers every command value against every ordered pair of severities, including the illegal one, and an arithmetic model in the bench predicts each result. Directed cases then cover a clear and a set in the same cycle, partial clears, the read-only source word, and the reset state.

// File: rtl/rterr_pkg.sv
// Shared constants and types for the root error collector.
// Assumes a fixed status layout, which software decodes by bit position.
package rterr_pkg;
    localparam int ST_W     = 7;
    localparam int CMD_W    = 3;
    localparam int ST_COR   = 0;   // correctable received
    localparam int ST_MCOR  = 1;   // multiple correctable
    localparam int ST_UNC   = 2;   // uncorrectable received
    localparam int ST_MUNC  = 3;   // multiple uncorrectable
    localparam int ST_FIRST = 4;   // first uncorrectable was fatal
    localparam int ST_NF    = 5;   // non-fatal received
    localparam int ST_FAT   = 6;   // fatal received

    localparam logic [1:0] ADDR_CMD = 2'd0;
    localparam logic [1:0] ADDR_ST  = 2'd1;
    localparam logic [1:0] ADDR_SRC = 2'd2;

    typedef enum logic [1:0] {
        SEV_COR   = 2'd0,
        SEV_NFAT  = 2'd1,
        SEV_FAT   = 2'd2,
        SEV_BAD   = 2'd3
    } sev_e;
endpackage

// File: rtl/rterr_next.sv
// Next-state logic for the status register.
// Decodes one message and merges its set bits with a software clear mask.
// Decisions on "already set" use the held status; sets win over clears.
module rterr_next
    import rterr_pkg::*;
(
    input  logic             msg_valid,
    input  logic [1:0]       msg_sev,
    input  logic [ST_W-1:0]  status_q,
    input  logic [ST_W-1:0]  clr_mask,
    output logic [ST_W-1:0]  status_d,
    output logic             cor_load,
    output logic             unc_load,
    output logic [CMD_W-1:0] sev_hit,
    output logic [CMD_W-1:0] pend_vec
);
    logic [ST_W-1:0] set_mask;
    logic            unc_msg;

    // Purpose: one-hot decode of a legal severity; illegal yields zero.
    always_comb begin
        sev_hit = '0;
        if (msg_valid) begin
            case (sev_e'(msg_sev))
                SEV_COR:  sev_hit[0] = 1'b1;
                SEV_NFAT: sev_hit[1] = 1'b1;
                SEV_FAT:  sev_hit[2] = 1'b1;
                default:  sev_hit    = '0;
            endcase
        end
    end

    assign unc_msg = sev_hit[1] | sev_hit[2];

    // Purpose: build the bits this message sets and the source-load strobes.
    always_comb begin
        set_mask = '0;
        cor_load = sev_hit[0] && !status_q[ST_COR];
        unc_load = unc_msg && !status_q[ST_UNC];
        if (sev_hit[0]) begin
            set_mask[ST_COR] = 1'b1;
            if (status_q[ST_COR]) set_mask[ST_MCOR] = 1'b1;
        end
        if (unc_msg) begin
            set_mask[ST_UNC] = 1'b1;
            if (status_q[ST_UNC]) set_mask[ST_MUNC] = 1'b1;
        end
        if (sev_hit[1]) set_mask[ST_NF] = 1'b1;
        if (sev_hit[2]) begin
            set_mask[ST_FAT] = 1'b1;
            if (!status_q[ST_UNC]) set_mask[ST_FIRST] = 1'b1;
        end
    end

    // Purpose: apply the clear first, then the set, so the set has priority.
    assign status_d = (status_q & ~clr_mask) | set_mask;

    // Purpose: map held status onto command-bit positions (cor, nf, fatal).
    assign pend_vec = {status_q[ST_FAT], status_q[ST_NF], status_q[ST_COR]};
endmodule

// File: rtl/rterr_irq.sv
// Interrupt generator: a one-cycle pulse when an enabled severity arrives
// and no enabled condition was pending beforehand.
// Assumes sev_hit is one-hot or zero and pend_vec is taken from held status.
module rterr_irq
    import rterr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMD_W-1:0] sev_hit,
    input  logic [CMD_W-1:0] pend_vec,
    input  logic [CMD_W-1:0] cmd_q,
    output logic             irq_o
);
    logic fire;

    assign fire = (|(sev_hit & cmd_q)) && !(|(pend_vec & cmd_q));

    // Purpose: register the request so it lasts one cycle per triggering message.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= fire;
    end
endmodule

// File: rtl/rterr_collector.sv
// Root error collector top: holds the command, status and source registers,
// and serves a combinational read port with write-1-to-clear status.
// Assumes at most one message per cycle and DATA_W >= 2*SRC_W.
module rterr_collector
    import rterr_pkg::*;
#(
    parameter int SRC_W  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_valid,
    input  logic [1:0]        msg_sev,
    input  logic [SRC_W-1:0]  msg_src,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);
    localparam int PAIR_W = 2 * SRC_W;

    logic [ST_W-1:0]  status_q, status_d, clr_mask;
    logic [CMD_W-1:0] cmd_q, sev_hit, pend_vec;
    logic [SRC_W-1:0] cor_src_q, unc_src_q;
    logic             cor_load, unc_load;
    logic             wdata_unused;

    assign wdata_unused = ^reg_wdata[DATA_W-1:ST_W];

    // Purpose: a write to the status address produces the clear mask.
    assign clr_mask = (reg_wr && reg_addr == ADDR_W'(ADDR_ST)) ? reg_wdata[ST_W-1:0] : '0;

    rterr_next u_next (
        .msg_valid (msg_valid),
        .msg_sev   (msg_sev),
        .status_q  (status_q),
        .clr_mask  (clr_mask),
        .status_d  (status_d),
        .cor_load  (cor_load),
        .unc_load  (unc_load),
        .sev_hit   (sev_hit),
        .pend_vec  (pend_vec)
    );

    rterr_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sev_hit  (sev_hit),
        .pend_vec (pend_vec),
        .cmd_q    (cmd_q),
        .irq_o    (irq_o)
    );

    // Purpose: status register update.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    // Purpose: command register, written by software only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= '0;
        else if (reg_wr && reg_addr == ADDR_W'(ADDR_CMD))
            cmd_q <= reg_wdata[CMD_W-1:0];
    end

    // Purpose: latch the source IDs of the first message of each class.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cor_src_q <= '0;
            unc_src_q <= '0;
        end else begin
            if (cor_load) cor_src_q <= msg_src;
            if (unc_load) unc_src_q <= msg_src;
        end
    end

    // Purpose: combinational read mux, zero-extended to the data width.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(ADDR_CMD): reg_rdata[CMD_W-1:0]  = cmd_q;
            ADDR_W'(ADDR_ST):  reg_rdata[ST_W-1:0]   = status_q;
            ADDR_W'(ADDR_SRC): reg_rdata[PAIR_W-1:0] = {unc_src_q, cor_src_q};
            default:           reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rterr_collector_chk.sv
// Property checker for the root error collector, attached by bind.
// Assumes it observes the top's held registers and its input ports.
module rterr_collector_chk
    import rterr_pkg::*;
#(
    parameter int SRC_W  = 16,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              msg_valid,
    input logic [1:0]        msg_sev,
    input logic [SRC_W-1:0]  msg_src,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              irq_o,
    input logic [ST_W-1:0]   status_q,
    input logic [CMD_W-1:0]  cmd_q,
    input logic [SRC_W-1:0]  cor_src_q,
    input logic [SRC_W-1:0]  unc_src_q
);
    logic [3:0]       chk_oh;
    logic [CMD_W-1:0] chk_pend;
    logic             chk_clr;

    assign chk_oh   = msg_valid ? (4'b0001 << msg_sev) : 4'b0000;
    assign chk_pend = {status_q[ST_FAT], status_q[ST_NF], status_q[ST_COR]};
    assign chk_clr  = reg_wr && reg_addr == ADDR_W'(ADDR_ST);

    assert_cor_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        chk_oh[0] && !status_q[ST_COR] |=> status_q[ST_COR] && cor_src_q == $past(msg_src));

    assert_cor_multi_R2: assert property (@(posedge clk) disable iff (!rst_n)
        chk_oh[0] && status_q[ST_COR] |=> status_q[ST_MCOR] && $stable(cor_src_q));

    assert_nonfatal_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        chk_oh[1] |=> status_q[ST_NF]);

    assert_fatal_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        chk_oh[2] && !status_q[ST_UNC] |=> status_q[ST_FIRST] && status_q[ST_FAT]);

    assert_unc_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_oh[1] || chk_oh[2]) && !status_q[ST_UNC] |=> unc_src_q == $past(msg_src));

    assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    assert_no_irq_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(chk_oh[2:0] & cmd_q)) |=> !irq_o);

    assert_no_irq_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(chk_pend & cmd_q)) |=> !irq_o);

    assert_illegal_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        chk_oh[3] && !chk_clr |=> $stable(status_q) && $stable(cor_src_q) && $stable(unc_src_q));

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        chk_oh[0] |=> status_q[ST_COR]);
endmodule

bind rterr_collector rterr_collector_chk #(.SRC_W(SRC_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_valid (msg_valid),
    .msg_sev   (msg_sev),
    .msg_src   (msg_src),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .irq_o     (irq_o),
    .status_q  (status_q),
    .cmd_q     (cmd_q),
    .cor_src_q (cor_src_q),
    .unc_src_q (unc_src_q)
);

// File: tb/rterr_collector_tb.sv
`timescale 1ns/1ps
module rterr_collector_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_valid = 1'b0;
    logic [1:0]  msg_sev = 2'd0;
    logic [15:0] msg_src = 16'd0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model, built from the requirements
    logic [6:0]  m_st = '0;
    logic [2:0]  m_cmd = '0;
    logic [15:0] m_cor = '0, m_unc = '0;
    logic        m_irq = 1'b0;

    always #4 clk = ~clk;

    rterr_collector u_dut (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_sev(msg_sev),
        .msg_src(msg_src), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    // Model: apply a message (and an optional clear in the same cycle).
    task automatic model_msg(input logic [1:0] sev, input logic [15:0] src, input logic [6:0] clr);
        logic [6:0] old;
        logic [2:0] pend;
        old = m_st;
        pend = {old[6], old[5], old[0]};
        m_st = m_st & ~clr;
        m_irq = 1'b0;
        if (sev == 2'd0) begin                    // R1 / R2
            if (old[0]) m_st[1] = 1'b1; else m_cor = src;
            m_st[0] = 1'b1;
        end
        if (sev == 2'd1) m_st[5] = 1'b1;          // R3
        if (sev == 2'd2) begin                    // R3 / R4
            if (!old[2]) m_st[4] = 1'b1;
            m_st[6] = 1'b1;
        end
        if (sev == 2'd1 || sev == 2'd2) begin     // R5
            if (old[2]) m_st[3] = 1'b1; else m_unc = src;
            m_st[2] = 1'b1;
        end
        if (sev != 2'd3)                          // R6 / R7 / R8 / R9
            m_irq = m_cmd[sev] && ((pend & m_cmd) == 3'b000);
    endtask

    task automatic send(input logic [1:0] sev, input logic [15:0] src);
        msg_valid = 1'b1; msg_sev = sev; msg_src = src;
        model_msg(sev, src, 7'd0);
        tick();
        msg_valid = 1'b0;
        chk("R6 irq after message", {31'd0, irq_o}, {31'd0, m_irq});
        rd_chk("R1-R5 status", 2'd1, {25'd0, m_st});
        rd_chk("R1 R5 source", 2'd2, {m_unc, m_cor});
        tick();
        chk("R6 irq one cycle", {31'd0, irq_o}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R11 reset state
        chk("R11 irq", {31'd0, irq_o}, 32'd0);
        rd_chk("R11 cmd", 2'd0, 32'd0);
        rd_chk("R11 status", 2'd1, 32'd0);
        rd_chk("R11 source", 2'd2, 32'd0);

        // R12 command width and read-only source word
        wr(2'd0, 32'hFFFF_FFF8);
        rd_chk("R12 cmd upper bits dropped", 2'd0, 32'd0);
        wr(2'd0, 32'h0000_0005);
        rd_chk("R12 cmd readback", 2'd0, 32'd5);
        wr(2'd2, 32'hDEAD_BEEF);
        rd_chk("R12 source write ignored", 2'd2, 32'd0);

        // Sweep: every command value against every ordered pair of severities
        for (int c = 0; c < 8; c++) begin
            for (int s1 = 0; s1 < 4; s1++) begin
                for (int s2 = 0; s2 < 4; s2++) begin
                    wr(2'd1, 32'h0000_007F);      // R10 clear all
                    m_st = '0;
                    rd_chk("R10 clear all", 2'd1, 32'd0);
                    wr(2'd0, 32'(c));
                    m_cmd = 3'(c);
                    send(2'(s1), 16'(c * 16 + s1 * 4 + s2 + 16'h1000));
                    send(2'(s2), 16'(c * 16 + s1 * 4 + s2 + 16'h2000));
                end
            end
        end

        // R10 partial clear leaves other bits set
        wr(2'd1, 32'h7F); m_st = '0;
        wr(2'd0, 32'd0); m_cmd = 3'd0;
        send(2'd0, 16'hA001);
        send(2'd0, 16'hA002);
        wr(2'd1, 32'h02); m_st[1] = 1'b0;
        rd_chk("R10 partial clear", 2'd1, {25'd0, m_st});

        // R10 clear and message in the same cycle: the set wins
        msg_valid = 1'b1; msg_sev = 2'd0; msg_src = 16'hB00B;
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h03;
        model_msg(2'd0, 16'hB00B, 7'h03);
        tick();
        msg_valid = 1'b0; reg_wr = 1'b0;
        rd_chk("R10 set beats clear", 2'd1, {25'd0, m_st});
        rd_chk("R2 source kept on simultaneous clear", 2'd2, {m_unc, m_cor});

        // R9 illegal severity with fatal enabled: no change, no interrupt
        wr(2'd1, 32'h7F); m_st = '0;
        wr(2'd0, 32'd7); m_cmd = 3'd7;
        send(2'd3, 16'hCCCC);
        rd_chk("R9 illegal leaves status clear", 2'd1, 32'd0);

        // R8 a pending enabled condition suppresses a new-severity interrupt
        send(2'd1, 16'hD001);
        send(2'd2, 16'hD002);
        chk("R8 fatal after pending non-fatal", {31'd0, irq_o}, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule